// File: doc/BRIEF.md
# Erasable Byte-Wide PROM Model

This block is a cycle-based, synthesizable stand-in for a byte-wide memory that can be written once and wiped clean by ultraviolet light. It stores 32768 bytes. Three control pins and a flag for the programming supply are decoded into one of seven modes: read, output off, standby, program, program check, program hold-off and identity readout. Read data leaves on an 8-bit bus with a separate enable flag in place of a floating output. All analog levels are digital flags here. `vpp_on` means the programming supply sits on the first select pin. `hv_flag` means the raised voltage on address line 9 that calls up the identity bytes.

Storage is arranged as 256 rows of 1024 bits. The upper 8 address bits pick the row. The lower 7 address bits drive eight 1-of-128 column selectors, one for each output bit. Programming can only clear bits. An erase request sweeps the rows one per clock and sets every cell back to one, and a busy flag stays high for the whole sweep. Control inputs are plain level signals sampled on every clock. There is no handshake: the caller holds a mode for as many cycles as it needs.

Top module: `eprom_core`

## Requirements
- R1: In read mode (`vpp_on`=0, `sel_a_n`=0, `sel_b`=1, `chip_en_n`=0), the byte stored at `addr` appears on `dout` with `dout_en`=1 after the next rising clock edge. Every address holds its own byte, and writing one address leaves its neighbours unchanged.
- R2: With `vpp_on`=0 and `chip_en_n`=1 (standby), `dout_en` and `dout` are 0 after the next edge, whatever `sel_a_n` and `sel_b` are.
- R3: With `vpp_on`=0 and `chip_en_n`=0, either `sel_a_n`=1, or `sel_b`=0 while `hv_flag`=0, turns the output off (`dout_en`=0, `dout`=0).
- R4: Program mode (`vpp_on`=1, `sel_b`=0, `chip_en_n`=1) writes `wr_data` to `addr` at the clock edge and keeps the output off.
- R5: Program check mode (`vpp_on`=1, `sel_b`=1, `chip_en_n`=0) drives the stored byte like a read.
- R6: Hold-off mode (`vpp_on`=1, `sel_b`=1, `chip_en_n`=1) changes no stored byte and keeps the output off.
- R7: With `vpp_on`=0, all three control pins low and `hv_flag`=1, the output is 0x34 when `addr[0]`=0 and 0x20 when `addr[0]`=1.
- R8: A program step stores the bitwise AND of the old byte and `wr_data`, so a bit can go from 1 to 0 but never back.
- R9: `erase_req`=1 while idle raises `erase_busy` at that edge. `erase_busy` then stays high for exactly 256 cycles, after which every byte reads 0xFF. A request made during a sweep has no effect.
- R10: While `erase_busy` is high, the output is off and program steps are ignored.
- R11: After reset, `dout`=0, `dout_en`=0 and `erase_busy`=0. The output always reflects the inputs sampled at the previous edge, one cycle of latency.
- R12: With `vpp_on`=1, `sel_b`=0 and `chip_en_n`=0, the output is off and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low (does not touch stored data) |
| sel_a_n | input | 1 | First select, active low (ignored while `vpp_on`=1) |
| sel_b | input | 1 | Second select, active high; program strobe, active low, while `vpp_on`=1 |
| chip_en_n | input | 1 | Chip enable, active low; check strobe while `vpp_on`=1 |
| vpp_on | input | 1 | Programming supply present on the first select pin |
| hv_flag | input | 1 | Raised voltage on address line 9 |
| addr | input | 15 | Byte address: row in bits 14..7, column in bits 6..0 |
| wr_data | input | 8 | Byte to program |
| erase_req | input | 1 | Start a full-array erase |
| dout | output | 8 | Output byte, 0 while off |
| dout_en | output | 1 | Output driven (0 stands for high impedance) |
| erase_busy | output | 1 | Erase sweep in progress |

## Verification
The hardest cases to reach from the pins happen inside the 256-cycle erase sweep. One is a program step that lands on a row the sweep has already cleared. The other is a second erase request arriving mid-sweep. The bench counts cycles from the accepted request. It programs address 0x0005, whose row is cleared first, a few cycles into the sweep, and it raises the request again later in the sweep. A missed write block shows up as a zero byte after the sweep, and a restarted sweep shows up as `erase_busy` outlasting 256 cycles. The rule that programming only clears bits is reached by programming the same byte twice with overlapping patterns.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  typedef enum logic [2:0] {
    M_STANDBY,
    M_OFF,
    M_READ,
    M_CHECK,
    M_PROGRAM,
    M_HOLD,
    M_IDENT
  } mode_e;

  localparam logic [7:0] IDENT_MAKER = 8'h34;
  localparam logic [7:0] IDENT_PART  = 8'h20;
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic  sel_a_n,
  input  logic  sel_b,
  input  logic  chip_en_n,
  input  logic  vpp_on,
  input  logic  hv_flag,
  output mode_e mode
);
  always_comb begin
    mode = M_OFF;
    if (vpp_on) begin
      unique case ({sel_b, chip_en_n})
        2'b01:   mode = M_PROGRAM;
        2'b10:   mode = M_CHECK;
        2'b11:   mode = M_HOLD;
        default: mode = M_OFF;
      endcase
    end else if (chip_en_n) begin
      mode = M_STANDBY;
    end else if (!sel_a_n && sel_b) begin
      mode = M_READ;
    end else if (!sel_a_n && !sel_b && hv_flag) begin
      mode = M_IDENT;
    end else begin
      mode = M_OFF;
    end
  end
endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
  parameter int ROW_AW = 8,
  parameter int COL_AW = 7,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ROW_AW-1:0]        row,
  input  logic [COL_AW-1:0]        col,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     erase_req,
  output logic [DATA_W*(1<<COL_AW)-1:0] rd_vec,
  output logic                     busy
);
  localparam int ROWS   = 1 << ROW_AW;
  localparam int COLS   = 1 << COL_AW;
  localparam int ROW_W  = DATA_W * COLS;

  logic [ROW_W-1:0]  cells [ROWS];
  logic [ROW_W-1:0]  clr_mask;
  logic [ROW_AW-1:0] sweep_row;

  // Bit b of the word in column c lives at position b*COLS + c of its row.
  always_comb begin
    clr_mask = '0;
    for (int b = 0; b < DATA_W; b++) begin
      clr_mask[b*COLS + int'(col)] = ~wr_data[b];
    end
  end

  assign rd_vec = cells[row];

  // Storage: the sweep has priority; a program step only clears bits.
  always_ff @(posedge clk) begin
    if (busy) begin
      cells[sweep_row] <= '1;
    end else if (wr_en) begin
      cells[row] <= cells[row] & ~clr_mask;
    end
  end

  // Row sweep sequencer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sweep_row <= '0;
    end else if (!busy) begin
      if (erase_req) begin
        busy      <= 1'b1;
        sweep_row <= '0;
      end
    end else if (sweep_row == ROW_AW'(ROWS - 1)) begin
      busy <= 1'b0;
    end else begin
      sweep_row <= sweep_row + 1'b1;
    end
  end
endmodule

// File: rtl/eprom_colmux.sv
module eprom_colmux #(
  parameter int COL_AW = 7,
  parameter int DATA_W = 8
) (
  input  logic [DATA_W*(1<<COL_AW)-1:0] rd_vec,
  input  logic [COL_AW-1:0]             col,
  output logic [DATA_W-1:0]             q
);
  localparam int COLS = 1 << COL_AW;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic [COLS-1:0] slice;
    assign slice = rd_vec[b*COLS +: COLS];
    assign q[b]  = slice[col];
  end
endmodule

// File: rtl/eprom_outreg.sv
module eprom_outreg
  import eprom_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode,
  input  logic              busy,
  input  logic              ident_sel,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else if (busy) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      unique case (mode)
        M_READ, M_CHECK: begin
          dout    <= rd_byte;
          dout_en <= 1'b1;
        end
        M_IDENT: begin
          dout    <= DATA_W'(ident_sel ? IDENT_PART : IDENT_MAKER);
          dout_en <= 1'b1;
        end
        default: begin
          dout    <= '0;
          dout_en <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/eprom_core.sv
module eprom_core
  import eprom_pkg::*;
#(
  parameter int ROW_AW = 8,
  parameter int COL_AW = 7,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel_a_n,
  input  logic                     sel_b,
  input  logic                     chip_en_n,
  input  logic                     vpp_on,
  input  logic                     hv_flag,
  input  logic [ROW_AW+COL_AW-1:0] addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     erase_req,
  output logic [DATA_W-1:0]        dout,
  output logic                     dout_en,
  output logic                     erase_busy
);
  localparam int ADDR_W = ROW_AW + COL_AW;
  localparam int ROW_W  = DATA_W * (1 << COL_AW);

  mode_e             mode;
  logic [ROW_AW-1:0] row;
  logic [COL_AW-1:0] col;
  logic [ROW_W-1:0]  rd_vec;
  logic [DATA_W-1:0] rd_byte;
  logic              wr_en;

  assign row   = addr[ADDR_W-1:COL_AW];
  assign col   = addr[COL_AW-1:0];
  assign wr_en = (mode == M_PROGRAM) && !erase_busy;

  eprom_mode_dec u_dec (
    .sel_a_n   (sel_a_n),
    .sel_b     (sel_b),
    .chip_en_n (chip_en_n),
    .vpp_on    (vpp_on),
    .hv_flag   (hv_flag),
    .mode      (mode)
  );

  eprom_array #(.ROW_AW(ROW_AW), .COL_AW(COL_AW), .DATA_W(DATA_W)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .row       (row),
    .col       (col),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .erase_req (erase_req),
    .rd_vec    (rd_vec),
    .busy      (erase_busy)
  );

  eprom_colmux #(.COL_AW(COL_AW), .DATA_W(DATA_W)) u_mux (
    .rd_vec (rd_vec),
    .col    (col),
    .q      (rd_byte)
  );

  eprom_outreg #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .busy      (erase_busy),
    .ident_sel (addr[0]),
    .rd_byte   (rd_byte),
    .dout      (dout),
    .dout_en   (dout_en)
  );
endmodule

// File: rtl/eprom_core_chk.sv
module eprom_core_chk
  import eprom_pkg::*;
#(
  parameter int ROW_AW = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              chip_en_n,
  input logic              vpp_on,
  input logic              hv_flag,
  input logic              addr0,
  input logic              erase_req,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              erase_busy
);
  localparam int ROWS = 1 << ROW_AW;

  logic [ROW_AW:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_cnt <= '0;
    else if (erase_busy) busy_cnt <= busy_cnt + 1'b1;
    else                 busy_cnt <= '0;
  end

  // R2
  standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vpp_on && chip_en_n) |=> (!dout_en && dout == '0));

  // R3
  sel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vpp_on && !chip_en_n && sel_a_n) |=> !dout_en);

  // R4
  program_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_on && !sel_b && chip_en_n) |=> !dout_en);

  // R6
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_on && sel_b && chip_en_n) |=> !dout_en);

  // R7
  ident_maker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!erase_busy && !vpp_on && !sel_a_n && !sel_b && !chip_en_n && hv_flag && !addr0)
      |=> (dout_en && dout == DATA_W'(IDENT_MAKER)));

  // R7
  ident_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!erase_busy && !vpp_on && !sel_a_n && !sel_b && !chip_en_n && hv_flag && addr0)
      |=> (dout_en && dout == DATA_W'(IDENT_PART)));

  // R9
  erase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && !erase_busy) |=> erase_busy);

  // R9
  erase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_busy) |-> (busy_cnt == (ROW_AW+1)'(ROWS)));

  // R10
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |=> !dout_en);

  // R12
  vpp_both_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_on && !sel_b && !chip_en_n) |=> !dout_en);
endmodule

bind eprom_core eprom_core_chk #(.ROW_AW(ROW_AW), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_a_n    (sel_a_n),
  .sel_b      (sel_b),
  .chip_en_n  (chip_en_n),
  .vpp_on     (vpp_on),
  .hv_flag    (hv_flag),
  .addr0      (addr[0]),
  .erase_req  (erase_req),
  .dout       (dout),
  .dout_en    (dout_en),
  .erase_busy (erase_busy)
);

// File: tb/sim_eprom_core.sv
module sim_eprom_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_a_n = 1'b1, sel_b = 1'b0, chip_en_n = 1'b1, vpp_on = 1'b0, hv_flag = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wr_data = '0;
  logic        erase_req = 1'b0;
  logic [7:0]  dout;
  logic        dout_en;
  logic        erase_busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    bit         ck_out;
    logic       en;
    logic [7:0] data;
    bit         ck_busy;
    logic       busy;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] model [int];

  always #10 clk = ~clk;

  eprom_core u0 (
    .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .chip_en_n(chip_en_n), .vpp_on(vpp_on), .hv_flag(hv_flag),
    .addr(addr), .wr_data(wr_data), .erase_req(erase_req),
    .dout(dout), .dout_en(dout_en), .erase_busy(erase_busy)
  );

  function automatic logic [7:0] peek(input int a);
    return model.exists(a) ? model[a] : 8'hFF;
  endfunction

  // Driver: one call is one clock cycle; the expectation is queued.
  task automatic step(input logic a_n, input logic b, input logic ce_n,
                      input logic vp, input logic hv, input logic [14:0] ad,
                      input logic [7:0] wd, input logic er,
                      input bit ck_out, input logic e_en, input logic [7:0] e_dat,
                      input bit ck_busy, input logic e_busy, input string tag);
    exp_t e;
    @(negedge clk);
    sel_a_n = a_n; sel_b = b; chip_en_n = ce_n; vpp_on = vp; hv_flag = hv;
    addr = ad; wr_data = wd; erase_req = er;
    e.ck_out = ck_out; e.en = e_en; e.data = e_dat;
    e.ck_busy = ck_busy; e.busy = e_busy; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic rd(input logic [14:0] a, input string tag);
    step(0, 1, 0, 0, 0, a, 8'h00, 0, 1, 1'b1, peek(int'(a)), 0, 0, tag);
  endtask

  task automatic prog(input logic [14:0] a, input logic [7:0] d, input string tag);
    step(1, 0, 1, 1, 0, a, d, 0, 1, 1'b0, 8'h00, 0, 0, tag);
    model[int'(a)] = peek(int'(a)) & d;
  endtask

  // Monitor: compares after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.ck_out) begin
          n_checks++;
          if (dout_en !== e.en || dout !== e.data) begin
            n_fail++;
            $display("FAIL %s: got en=%0b data=%02h, expected en=%0b data=%02h",
                     e.tag, dout_en, dout, e.en, e.data);
          end
        end
        if (e.ck_busy) begin
          n_checks++;
          if (erase_busy !== e.busy) begin
            n_fail++;
            $display("FAIL %s: got busy=%0b, expected busy=%0b", e.tag, erase_busy, e.busy);
          end
        end
      end
    end
  end

  task automatic erase_all(input string tag, input bit poke);
    step(1, 0, 1, 0, 0, 15'h0, 8'h00, 1, 1, 1'b0, 8'h00, 1, 1'b1, tag);
    for (int k = 1; k <= 256; k++) begin
      if (poke && k == 5)
        // R10: program into already-swept row 0 must be ignored
        step(1, 0, 1, 1, 0, 15'h0005, 8'h00, 0, 1, 1'b0, 8'h00, 1, 1'b1, "R10 program in sweep");
      else if (poke && k == 40)
        // R9: second request mid-sweep must not restart it
        step(0, 1, 0, 0, 0, 15'h0, 8'h00, 1, 1, 1'b0, 8'h00, 1, 1'b1, "R9 request while busy");
      else
        step(0, 1, 0, 0, 0, 15'h1234, 8'h00, 0, 1, 1'b0, 8'h00, 1, (k < 256), "R10 out off in sweep / R9 length");
    end
    model.delete();
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    n_checks++;
    if (dout !== 8'h00 || dout_en !== 1'b0 || erase_busy !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 reset: got en=%0b data=%02h busy=%0b, expected 0 00 0", dout_en, dout, erase_busy);
    end
    rst_n = 1'b1;

    erase_all("R9 first erase", 0);
    rd(15'h1234, "R9 erased reads FF");
    prog(15'h1234, 8'hA5, "R4 program out off");
    rd(15'h1234, "R1 R11 read after program");
    prog(15'h1234, 8'h3C, "R4 second program");
    rd(15'h1234, "R8 AND of old and new");
    step(0, 1, 0, 1, 0, 15'h1234, 8'h00, 0, 1, 1'b1, peek(32'h1234), 0, 0, "R5 check mode");
    step(0, 1, 1, 1, 0, 15'h1234, 8'h00, 0, 1, 1'b0, 8'h00, 0, 0, "R6 hold off");
    rd(15'h1234, "R6 unchanged after hold");
    step(0, 0, 0, 1, 0, 15'h1234, 8'h00, 0, 1, 1'b0, 8'h00, 0, 0, "R12 vpp both low");
    rd(15'h1234, "R12 unchanged");
    step(0, 1, 1, 0, 0, 15'h1234, 8'h00, 0, 1, 1'b0, 8'h00, 0, 0, "R2 standby sel on");
    step(1, 0, 1, 0, 1, 15'h1234, 8'h00, 0, 1, 1'b0, 8'h00, 0, 0, "R2 standby sel off");
    step(1, 1, 0, 0, 0, 15'h1234, 8'h00, 0, 1, 1'b0, 8'h00, 0, 0, "R3 sel_a high");
    step(0, 0, 0, 0, 0, 15'h1234, 8'h00, 0, 1, 1'b0, 8'h00, 0, 0, "R3 sel_b low no hv");
    step(0, 0, 0, 0, 1, 15'h0000, 8'h00, 0, 1, 1'b1, 8'h34, 0, 0, "R7 maker byte");
    step(0, 0, 0, 0, 1, 15'h0001, 8'h00, 0, 1, 1'b1, 8'h20, 0, 0, "R7 part byte");
    step(0, 1, 0, 0, 1, 15'h1234, 8'h00, 0, 1, 1'b1, peek(32'h1234), 0, 0, "R1 hv ignored in read");
    prog(15'h0000, 8'h01, "R4 corner low");
    prog(15'h7FFF, 8'h80, "R4 corner high");
    prog(15'h007F, 8'h5A, "R4 last column");
    prog(15'h0080, 8'hC3, "R4 next row");
    rd(15'h0000, "R1 addr 0000");
    rd(15'h7FFF, "R1 addr 7FFF");
    rd(15'h007F, "R1 addr 007F");
    rd(15'h0080, "R1 addr 0080");
    rd(15'h0001, "R1 neighbour untouched");
    rd(15'h7FFE, "R1 neighbour untouched high");

    erase_all("R9 second erase", 1);
    step(0, 1, 0, 0, 0, 15'h0000, 8'h00, 0, 1, 1'b1, 8'hFF, 1, 1'b0, "R9 busy low after 256");
    rd(15'h0005, "R10 ignored program");
    rd(15'h1234, "R9 erased 1234");
    rd(15'h7FFF, "R9 erased 7FFF");
    rd(15'h0080, "R9 erased 0080");

    step(1, 0, 1, 0, 0, 15'h0, 8'h00, 0, 0, 1'b0, 8'h00, 0, 0, "idle");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule